// File: doc/BRIEF.md
# UART Sleep and Wake Controller

This block manages power for one UART channel. It watches the channel's interrupt status, divisor, modem-status deltas, receive line and transmit loads. When the channel is idle and sleep is enabled, it turns off the baud oscillator. When activity returns, it turns the oscillator back on. It also gates the line-driver charge pump, unless a strap pin keeps the pump on at all times.

The controller runs on a slow clock that never stops. The receive line and the modem deltas reach it through two-flop synchronizers. A wake event seen while asleep is held until the oscillator has settled. The controller then gives the oscillator a fixed 16-cycle settling time and raises a wake interrupt. That interrupt reports the same 4-bit source code, 0x1, as "nothing pending". It has the lowest priority and clears when the host reads the interrupt status. Once every interrupt has been serviced, the block goes back to sleep without any host action.

Top module: `uart_sleep_ctl`

## Requirements
- R1: After reset the oscillator enable and charge-pump enable are 1 and the wake request is 0.
- R2: The oscillator enable drops to 0 within 6 clock cycles once all five sleep conditions hold together. The conditions are: bit 0 of the incoming interrupt code is 1 (no source pending); the divisor is non-zero; sleep is enabled; all modem delta bits are 0; the receive line is LOW.
- R3: If any one of the sleep conditions in R2 is false, the oscillator enable stays at 1.
- R4: While asleep, a LOW-to-HIGH change on the receive line turns the oscillator enable on within 5 cycles.
- R5: While asleep, a one-cycle transmit-load strobe or a non-zero modem delta wakes the block.
- R6: After a wake caused by the modem deltas, sleep is not re-entered until the host strobes the modem-status read, even if the deltas have already returned to 0.
- R7: After a wake event, the oscillator enable is 1 during a 16-cycle settling period. The wake request stays 0 during that period and becomes 1 after it, provided sleep is still enabled.
- R8: The output interrupt code equals the incoming code whenever the incoming bit 0 is 0. Otherwise it is 4'h1, whether or not a wake request is pending.
- R9: An interrupt-status read clears the wake request only when the incoming code has bit 0 equal to 1. Once the request is cleared and the sleep conditions hold, the block sleeps again.
- R10: Clearing the sleep enable while asleep wakes the block without raising the wake request, and the block stays awake.
- R11: The charge-pump enable is 1 whenever the pump-hold strap is LOW. When the strap is HIGH, the charge-pump enable equals the oscillator enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_code_in | input | 4 | Interrupt code from the UART; bit 0 = 1 means none pending |
| divisor | input | 16 | Programmed baud divisor |
| sleep_en | input | 1 | Sleep enable bit |
| msr_delta | input | 4 | Modem-status change bits |
| rxd | input | 1 | Receive line level |
| tx_load | input | 1 | One-cycle strobe: byte written to the transmitter |
| isr_rd | input | 1 | Host read strobe of interrupt status |
| msr_rd | input | 1 | Host read strobe of modem status |
| pump_hold_n | input | 1 | Strap; LOW keeps the charge pump always on |
| osc_en | output | 1 | Oscillator enable |
| pump_en | output | 1 | Charge-pump enable |
| wake_irq | output | 1 | Wake interrupt request |
| irq_code | output | 4 | Interrupt code presented to the host |

## Verification
The bench checks that a wake request is absent during the settling window. A design that raised it early would report wake before the clock is usable. It also reads the interrupt status while a higher-priority source is present. A design with the priority wrong would either show 0x1 instead of that source, or drop the wake request when the read was meant for the other source. The bench lets the modem deltas fall back to 0 without a modem-status read. A design that forgot the earlier modem wake would go back to sleep too early. Finally, clearing the sleep enable while asleep must wake the block without a spurious interrupt. Randomized trials combine the five sleep conditions with the pump strap and compare against a computed expectation.

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl #(
  parameter int DIV_W      = 16,
  parameter int MSR_W      = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       irq_code_in,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sleep_en,
  input  logic [MSR_W-1:0] msr_delta,
  input  logic             rxd,
  input  logic             tx_load,
  input  logic             isr_rd,
  input  logic             msr_rd,
  input  logic             pump_hold_n,
  output logic             osc_en,
  output logic             pump_en,
  output logic             wake_irq,
  output logic [3:0]       irq_code
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_SETTLE} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic             woke, modem_hold;
  logic             rx_m, rx_s, rx_q;
  logic [MSR_W-1:0] msr_m, msr_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b0; rx_s <= 1'b0; rx_q <= 1'b0;
      msr_m <= '0;  msr_s <= '0;
    end else begin
      rx_m <= rxd;  rx_s <= rx_m; rx_q <= rx_s;
      msr_m <= msr_delta; msr_s <= msr_m;
    end

  wire idle_src    = irq_code_in[0];
  wire wake_evt    = (rx_s & ~rx_q) | tx_load | (|msr_s);
  wire can_sleep   = idle_src & ~wake_irq & (|divisor) & sleep_en &
                     ~(|msr_s) & ~modem_hold & ~rx_s & ~tx_load;
  wire settle_done = (state == ST_SETTLE) && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
      woke  <= 1'b0;
    end else begin
      case (state)
        ST_RUN:   if (can_sleep) state <= ST_SLEEP;
        ST_SLEEP: if (wake_evt || !sleep_en) begin
          state <= ST_SETTLE;
          cnt   <= '0;
          woke  <= wake_evt;
        end
        ST_SETTLE: begin
          cnt <= cnt + 1'b1;
          if (settle_done) begin
            state <= ST_RUN;
            woke  <= 1'b0;
          end
        end
        default: state <= ST_RUN;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 modem_hold <= 1'b0;
    else if (state == ST_SLEEP && (|msr_s))     modem_hold <= 1'b1;
    else if (msr_rd)                            modem_hold <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 wake_irq <= 1'b0;
    else if (settle_done && woke && sleep_en)   wake_irq <= 1'b1;
    else if (isr_rd && idle_src)                wake_irq <= 1'b0;

  assign osc_en   = (state != ST_SLEEP);
  assign pump_en  = ~pump_hold_n | osc_en;
  assign irq_code = idle_src ? 4'h1 : irq_code_in;

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && $past(state) == ST_RUN) |->
      $past(idle_src && sleep_en && (|divisor) && !wake_irq && !modem_hold));

  // R7
  irq_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(state == ST_SETTLE));

  // R9
  awake_while_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> state != ST_SLEEP);

  // R6
  modem_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_hold && state == ST_RUN) |=> state != ST_SLEEP);

  // R10
  disable_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !sleep_en) |=> state == ST_SETTLE);

endmodule

// File: tb/uart_sleep_ctl_bench.sv
module uart_sleep_ctl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  irq_code_in = 4'h1;
  logic [15:0] divisor = 16'd12;
  logic        sleep_en = 1'b0;
  logic [3:0]  msr_delta = 4'h0;
  logic        rxd = 1'b0, tx_load = 1'b0, isr_rd = 1'b0, msr_rd = 1'b0;
  logic        pump_hold_n = 1'b1;
  logic        osc_en, pump_en, wake_irq;
  logic [3:0]  irq_code;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  uart_sleep_ctl u_uart_sleep_ctl (
    .clk, .rst_n, .irq_code_in, .divisor, .sleep_en, .msr_delta, .rxd,
    .tx_load, .isr_rd, .msr_rd, .pump_hold_n,
    .osc_en, .pump_en, .wake_irq, .irq_code);

  function automatic bit exp_asleep(logic [3:0] c, logic [15:0] d,
                                    logic en, logic [3:0] m, logic r);
    return c[0] && (d != 0) && en && (m == 0) && !r;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse_isr();  isr_rd = 1'b1;  cyc(1); isr_rd = 1'b0;  endtask
  task automatic pulse_msr();  msr_rd = 1'b1;  cyc(1); msr_rd = 1'b0;  endtask
  task automatic pulse_tx();   tx_load = 1'b1; cyc(1); tx_load = 1'b0; endtask

  task automatic go_sleep();
    irq_code_in = 4'h1; divisor = 16'd12; msr_delta = 4'h0; rxd = 1'b0;
    sleep_en = 1'b1;
    cyc(6);
  endtask

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pump_en", pump_en, 1);
    chk("R1 wake_irq", wake_irq, 0);

    for (int t = 0; t < 60; t++) begin
      logic [3:0]  c, m;
      logic [15:0] d;
      logic        en, r, hold;
      bit          e;
      sleep_en = 1'b0;
      cyc(25);
      c    = ($urandom % 4 == 0) ? 4'h6 : 4'h1;
      d    = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom % 65535 + 1);
      en   = ($urandom % 5 != 0);
      m    = ($urandom % 4 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      r    = ($urandom % 4 == 0);
      hold = 1'($urandom % 2);
      irq_code_in = c; divisor = d; sleep_en = en; msr_delta = m; rxd = r;
      pump_hold_n = hold;
      cyc(6);
      e = exp_asleep(c, d, en, m, r);
      // R2 / R3 / R11
      chk(e ? "R2 sleep entry" : "R3 sleep blocked", osc_en, !e);
      chk("R11 pump", pump_en, (!hold) || !e);
      // R8
      chk("R8 code", irq_code, c);
    end

    sleep_en = 1'b0; pump_hold_n = 1'b1;
    cyc(25);
    go_sleep();
    chk("R2 asleep", osc_en, 0);
    chk("R11 pump off", pump_en, 0);
    pump_hold_n = 1'b0; cyc(1);
    chk("R11 pump held", pump_en, 1);
    pump_hold_n = 1'b1;

    rxd = 1'b1;
    cyc(5);
    chk("R4 rx wake", osc_en, 1);
    cyc(5);
    chk("R7 no early irq", wake_irq, 0);
    chk("R7 osc during settle", osc_en, 1);
    cyc(15);
    chk("R7 irq after settle", wake_irq, 1);
    chk("R8 wake code", irq_code, 4'h1);
    irq_code_in = 4'h4;
    cyc(1);
    chk("R8 priority", irq_code, 4'h4);
    pulse_isr();
    chk("R9 read kept", wake_irq, 1);
    irq_code_in = 4'h1;
    pulse_isr();
    chk("R9 read cleared", wake_irq, 0);
    chk("R9 awake with rx high", osc_en, 1);
    rxd = 1'b0;
    cyc(6);
    chk("R9 resleep", osc_en, 0);

    pulse_tx();
    cyc(24);
    chk("R5 tx wake", osc_en, 1);
    chk("R5 tx irq", wake_irq, 1);
    pulse_isr();
    cyc(6);
    chk("R9 resleep after tx", osc_en, 0);

    msr_delta = 4'h4;
    cyc(25);
    chk("R5 modem wake", osc_en, 1);
    chk("R5 modem irq", wake_irq, 1);
    msr_delta = 4'h0;
    pulse_isr();
    cyc(8);
    chk("R6 held awake", osc_en, 1);
    pulse_msr();
    cyc(6);
    chk("R6 sleep after msr read", osc_en, 0);

    sleep_en = 1'b0;
    cyc(25);
    chk("R10 woken", osc_en, 1);
    chk("R10 no irq", wake_irq, 0);
    cyc(10);
    chk("R10 stays awake", osc_en, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule